// File: doc/BRIEF.md
# Bitplane Pass and Neighbour Significance Unit

This block sits in the bit-modelling front end of a wavelet-domain block coder that encodes every magnitude bitplane of a code block in a single scan. Each clock it takes one centre coefficient magnitude, the magnitudes of its eight neighbours, a flag per neighbour that records the pass in which that neighbour's leading one was coded, and the row of the centre within its four-row stripe. From these it produces, for all bitplanes at once, the coding pass of the centre and the number of significant horizontal, vertical and diagonal neighbours. It does not keep per-bitplane significance state. A neighbour's significance in a given plane follows from where its leading one sits relative to that plane. When the plane is the neighbour's own leading-one plane, the neighbour's stored pass flag and its scan position relative to the centre decide.

The block also returns the centre's own leading-one pass flag. The caller stores this flag beside the coefficient and feeds it back as a neighbour flag when later samples are processed. Both stages are combinational, and all results are registered once. Downstream context mapping takes the per-plane pass code and the sums.

Top module: `bitplane_pass_hvd`

## Requirements
- R1: When `in_valid` is high, every output is updated on the next rising clock edge and `out_valid` is high for that one cycle. While `in_valid` is low, `out_valid` is low and the pass and sum outputs keep their previous values.
- R2: While reset is active, `out_valid`, `ctr_mp` and all pass and sum outputs are zero.
- R3: For plane k, the pass field `pass_o[2k+1:2k]` is 2 (refinement) whenever the centre magnitude has a one in a bit above k.
- R4: For a plane at or above the centre's leading one, and for every plane of a zero centre, the pass field is 1 (significance propagation) if any neighbour is significant in that plane and 3 (cleanup) otherwise. The value 0 never appears.
- R5: The neighbour in slot j occupies `nbr_mag[8j+7:8j]` (the field is NBP bits wide, 8 by default), and its flag is `nbr_mp[j]`. The slots are 0 upper-left, 1 up, 2 upper-right, 3 left, 4 right, 5 lower-left, 6 down, 7 lower-right. A neighbour is significant in plane k when its leading one is in a bit above k. It is never significant in a plane above its leading one.
- R6: In its own leading-one plane, a neighbour scanned before the centre (slots 0, 1, 3, 5) is significant exactly when its `nbr_mp` bit is 1. A neighbour scanned after the centre (slots 4, 6, 7) is not significant there.
- R7: The upper-right neighbour (slot 2) is treated as scanned before the centre when `row` is 0 and as scanned after it for `row` 1 to 3.
- R8: When `row` is 3, slots 5, 6 and 7 lie in the next stripe and are never significant, whatever their magnitude.
- R9: For plane k, `h_sum[2k+1:2k]` counts significant slots 3 and 4, `v_sum[2k+1:2k]` counts slots 1 and 6, and `d_sum[3k+2:3k]` counts slots 0, 2, 5 and 7.
- R10: `ctr_mp` is 1 exactly when at least one neighbour is significant in the centre's leading-one plane. It is 0 for a zero centre, so it equals whether that plane's pass is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | Window inputs are valid this cycle |
| ctr_mag | input | NBP | Centre coefficient magnitude |
| nbr_mag | input | 8*NBP | Eight neighbour magnitudes, slot order as in R5 |
| nbr_mp | input | 8 | Stored leading-one pass flag per neighbour slot |
| row | input | 2 | Row of the centre inside its stripe, 0 at the top |
| out_valid | output | 1 | Results below were loaded this cycle |
| ctr_mp | output | 1 | Leading-one pass flag of the centre |
| pass_o | output | 2*NBP | Pass code per plane: 1 propagation, 2 refinement, 3 cleanup |
| h_sum | output | 2*NBP | Horizontal significant-neighbour count per plane |
| v_sum | output | 2*NBP | Vertical significant-neighbour count per plane |
| d_sum | output | 3*NBP | Diagonal significant-neighbour count per plane |

## Verification
The properties assume that `ctr_mag` is the value that was sampled with `in_valid` one cycle earlier, so each check looks back exactly one cycle from `out_valid`. They also assume that `in_valid` is driven only after the synchronized reset has been released. The stimulus follows both rules. It changes inputs only half a period away from the sampling edge and waits several cycles after reset before the first item. Directed windows place leading ones equal to, above and below the centre's leading one in each slot, with both flag values and every row value. Pseudo-random windows are built so that equal leading-one planes occur often.

// File: rtl/bph_pkg.sv
package bph_pkg;

  localparam int NNBR = 8;

  // neighbour slot numbering, row-major around the centre
  localparam int SL_UL = 0;
  localparam int SL_U  = 1;
  localparam int SL_UR = 2;
  localparam int SL_L  = 3;
  localparam int SL_R  = 4;
  localparam int SL_DL = 5;
  localparam int SL_D  = 6;
  localparam int SL_DR = 7;

  typedef enum logic [1:0] {
    PASS_NONE   = 2'd0,
    PASS_SPROP  = 2'd1,
    PASS_REFINE = 2'd2,
    PASS_CLEAN  = 2'd3
  } pass_e;

  // scan position of a neighbour relative to the centre
  typedef enum logic [1:0] {
    NK_BEFORE = 2'd0,
    NK_AFTER  = 2'd1,
    NK_TURN   = 2'd2
  } nbr_kind_e;

  function automatic nbr_kind_e slot_kind(input int s);
    case (s)
      SL_UL, SL_U, SL_L, SL_DL: slot_kind = NK_BEFORE;
      SL_UR:                    slot_kind = NK_TURN;
      default:                  slot_kind = NK_AFTER;
    endcase
  endfunction

  function automatic bit slot_low(input int s);
    slot_low = (s == SL_DL) || (s == SL_D) || (s == SL_DR);
  endfunction

endpackage

// File: rtl/bph_msb_locate.sv
module bph_msb_locate #(
  parameter int NBP = 8
) (
  input  logic [NBP-1:0] mag,
  output logic [NBP-1:0] top,
  output logic [NBP-1:0] under
);

  logic seen;

  always_comb begin
    seen = 1'b0;
    top = '0;
    under = '0;
    for (int k = NBP - 1; k >= 0; k--) begin
      top[k]   = mag[k] & ~seen;
      under[k] = seen;
      seen     = seen | mag[k];
    end
  end

endmodule

// File: rtl/bph_nbr_elem.sv
module bph_nbr_elem
  import bph_pkg::*;
#(
  parameter int        NBP         = 8,
  parameter nbr_kind_e KIND        = NK_AFTER,
  parameter bit        IN_NEXT_ROW = 1'b0
) (
  input  logic [NBP-1:0] mag,
  input  logic           mp,
  input  logic [1:0]     row,
  output logic [NBP-1:0] sig
);

  logic [NBP-1:0] top;
  logic [NBP-1:0] under;
  logic           scanned_first;
  logic           blocked;

  bph_msb_locate #(.NBP(NBP)) u_loc (
    .mag   (mag),
    .top   (top),
    .under (under)
  );

  always_comb begin
    scanned_first = (KIND == NK_BEFORE) || ((KIND == NK_TURN) && (row == 2'd0));
    blocked       = IN_NEXT_ROW && (row == 2'd3);
    for (int k = 0; k < NBP; k++) begin
      sig[k] = ~blocked & (under[k] | (top[k] & scanned_first & mp));
    end
  end

endmodule

// File: rtl/bph_msb_pass.sv
module bph_msb_pass #(
  parameter int NBP = 8
) (
  input  logic [NBP-1:0] ctr_top,
  input  logic [NBP-1:0] any_sig,
  output logic           mp
);

  assign mp = |(ctr_top & any_sig);

endmodule

// File: rtl/bitplane_pass_hvd.sv
module bitplane_pass_hvd
  import bph_pkg::*;
#(
  parameter int NBP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NBP-1:0]       ctr_mag,
  input  logic [NNBR*NBP-1:0]  nbr_mag,
  input  logic [NNBR-1:0]      nbr_mp,
  input  logic [1:0]           row,
  output logic                 out_valid,
  output logic                 ctr_mp,
  output logic [2*NBP-1:0]     pass_o,
  output logic [2*NBP-1:0]     h_sum,
  output logic [2*NBP-1:0]     v_sum,
  output logic [3*NBP-1:0]     d_sum
);

  logic [1:0]     rsync_q;
  logic           rst_q_n;
  logic [NBP-1:0] nsig [NNBR];
  logic [NBP-1:0] ctr_top;
  logic [NBP-1:0] ctr_under;
  logic [NBP-1:0] any_sig;
  logic           mp_n;
  logic [2*NBP-1:0] pass_n;
  logic [2*NBP-1:0] h_n;
  logic [2*NBP-1:0] v_n;
  logic [3*NBP-1:0] d_n;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  bph_msb_locate #(.NBP(NBP)) u_ctr (
    .mag   (ctr_mag),
    .top   (ctr_top),
    .under (ctr_under)
  );

  for (genvar j = 0; j < NNBR; j++) begin : g_nbr
    bph_nbr_elem #(
      .NBP         (NBP),
      .KIND        (slot_kind(j)),
      .IN_NEXT_ROW (slot_low(j))
    ) u_elem (
      .mag (nbr_mag[j*NBP +: NBP]),
      .mp  (nbr_mp[j]),
      .row (row),
      .sig (nsig[j])
    );
  end

  always_comb begin
    any_sig = '0;
    for (int j = 0; j < NNBR; j++) any_sig = any_sig | nsig[j];
  end

  // stage 1: pass of the centre's leading-one plane
  bph_msb_pass #(.NBP(NBP)) u_mp (
    .ctr_top (ctr_top),
    .any_sig (any_sig),
    .mp      (mp_n)
  );

  // stage 2: per-plane pass and grouped neighbour counts
  always_comb begin
    for (int k = 0; k < NBP; k++) begin
      if (ctr_under[k])    pass_n[2*k +: 2] = PASS_REFINE;
      else if (any_sig[k]) pass_n[2*k +: 2] = PASS_SPROP;
      else                 pass_n[2*k +: 2] = PASS_CLEAN;
      h_n[2*k +: 2] = 2'(nsig[SL_L][k]) + 2'(nsig[SL_R][k]);
      v_n[2*k +: 2] = 2'(nsig[SL_U][k]) + 2'(nsig[SL_D][k]);
      d_n[3*k +: 3] = 3'(nsig[SL_UL][k]) + 3'(nsig[SL_UR][k])
                    + 3'(nsig[SL_DL][k]) + 3'(nsig[SL_DR][k]);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) out_valid <= 1'b0;
    else          out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctr_mp <= 1'b0;
      pass_o <= '0;
      h_sum  <= '0;
      v_sum  <= '0;
      d_sum  <= '0;
    end else if (in_valid) begin
      ctr_mp <= mp_n;
      pass_o <= pass_n;
      h_sum  <= h_n;
      v_sum  <= v_n;
      d_sum  <= d_n;
    end
  end

endmodule

// File: rtl/bph_checker.sv
module bph_checker #(
  parameter int NBP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [NBP-1:0]   ctr_mag,
  input logic             out_valid,
  input logic             ctr_mp,
  input logic [2*NBP-1:0] pass_o,
  input logic [2*NBP-1:0] h_sum,
  input logic [2*NBP-1:0] v_sum,
  input logic [3*NBP-1:0] d_sum
);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pass_o) && $stable(h_sum) && $stable(v_sum)
                   && $stable(d_sum) && $stable(ctr_mp)));

  p_zero_centre_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(ctr_mag) == '0)) |-> !ctr_mp);

  for (genvar k = 0; k < NBP; k++) begin : g_plane
    p_refine_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (($past(ctr_mag) >> (k + 1)) != '0)) |-> (pass_o[2*k +: 2] == 2'd2));

    p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (pass_o[2*k +: 2] != 2'd0));

    p_clean_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (pass_o[2*k +: 2] == 2'd3)) |->
        ((h_sum[2*k +: 2] == 2'd0) && (v_sum[2*k +: 2] == 2'd0) && (d_sum[3*k +: 3] == 3'd0)));

    p_mp_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(ctr_mag[k]) && (($past(ctr_mag) >> (k + 1)) == '0)) |->
        (ctr_mp == (pass_o[2*k +: 2] == 2'd1)));
  end

endmodule

bind bitplane_pass_hvd bph_checker #(.NBP(NBP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .in_valid  (in_valid),
  .ctr_mag   (ctr_mag),
  .out_valid (out_valid),
  .ctr_mp    (ctr_mp),
  .pass_o    (pass_o),
  .h_sum     (h_sum),
  .v_sum     (v_sum),
  .d_sum     (d_sum)
);

// File: tb/sim_bitplane_pass_hvd.sv
module sim_bitplane_pass_hvd;

  localparam int CLK_PERIOD = 10;
  localparam int NBP = 8;
  localparam int EW  = 1 + 9 * NBP;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [NBP-1:0]       ctr_mag = '0;
  logic [8*NBP-1:0]     nbr_mag = '0;
  logic [7:0]           nbr_mp = '0;
  logic [1:0]           row = '0;
  logic                 out_valid;
  logic                 ctr_mp;
  logic [2*NBP-1:0]     pass_o;
  logic [2*NBP-1:0]     h_sum;
  logic [2*NBP-1:0]     v_sum;
  logic [3*NBP-1:0]     d_sum;

  int checks = 0;
  int errors = 0;
  logic [EW-1:0] expq[$];
  string         tagq[$];
  logic [2*NBP-1:0] last_pass = '0;
  bit            seen_any = 1'b0;
  logic [31:0]   lcg = 32'h1234_5678;

  bitplane_pass_hvd #(.NBP(NBP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctr_mag(ctr_mag),
    .nbr_mag(nbr_mag), .nbr_mp(nbr_mp), .row(row), .out_valid(out_valid),
    .ctr_mp(ctr_mp), .pass_o(pass_o), .h_sum(h_sum), .v_sum(v_sum), .d_sum(d_sum)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic int lead(input logic [NBP-1:0] m);
    for (int k = NBP - 1; k >= 0; k--) if (m[k]) return k;
    return -1;
  endfunction

  // R5 R6 R7 R8: significance of slot s in plane k
  function automatic bit contrib(input int s, input int k, input logic [NBP-1:0] m,
                                 input logic f, input logic [1:0] r);
    int  l;
    bit  first;
    if (r == 2'd3 && s >= 5) return 1'b0;
    l = lead(m);
    if (l > k) return 1'b1;
    if (l == k) begin
      first = (s == 0) || (s == 1) || (s == 3) || (s == 5) || (s == 2 && r == 2'd0);
      return first && f;
    end
    return 1'b0;
  endfunction

  function automatic logic [EW-1:0] model(input logic [NBP-1:0] c, input logic [8*NBP-1:0] n,
                                          input logic [7:0] f, input logic [1:0] r);
    logic [NBP-1:0]   any;
    logic [2*NBP-1:0] ps, hs, vs;
    logic [3*NBP-1:0] ds;
    logic             m;
    int               lc;
    lc = lead(c);
    any = '0; ps = '0; hs = '0; vs = '0; ds = '0;
    for (int k = 0; k < NBP; k++) begin
      int h, v, d;
      h = 0; v = 0; d = 0;
      for (int s = 0; s < 8; s++) begin
        if (contrib(s, k, n[s*NBP +: NBP], f[s], r)) begin
          any[k] = 1'b1;
          if (s == 3 || s == 4)      h++;
          else if (s == 1 || s == 6) v++;
          else                       d++;
        end
      end
      if (lc > k)      ps[2*k +: 2] = 2'd2;
      else if (any[k]) ps[2*k +: 2] = 2'd1;
      else             ps[2*k +: 2] = 2'd3;
      hs[2*k +: 2] = 2'(h);
      vs[2*k +: 2] = 2'(v);
      ds[3*k +: 3] = 3'(d);
    end
    m = (lc >= 0) ? any[lc] : 1'b0;
    return {m, ps, hs, vs, ds};
  endfunction

  function automatic logic [8*NBP-1:0] at(input int s, input logic [NBP-1:0] m);
    logic [8*NBP-1:0] v;
    v = '0;
    v[s*NBP +: NBP] = m;
    return v;
  endfunction

  task automatic send(input string tag, input logic [NBP-1:0] c, input logic [8*NBP-1:0] n,
                      input logic [7:0] f, input logic [1:0] r);
    @(negedge clk);
    ctr_mag = c; nbr_mag = n; nbr_mp = f; row = r; in_valid = 1'b1;
    expq.push_back(model(c, n, f, r));
    tagq.push_back(tag);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      ctr_mag = ~ctr_mag;
    end
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check("R1", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        logic [EW-1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(t, "pass", 32'(pass_o), 32'(e[EW-2 -: 2*NBP]));
        check(t, "h_sum", 32'(h_sum), 32'(e[7*NBP-1 -: 2*NBP]));
        check(t, "v_sum", 32'(v_sum), 32'(e[5*NBP-1 -: 2*NBP]));
        check(t, "d_sum", 32'(d_sum), 32'(e[3*NBP-1:0]));
        check(t, "ctr_mp", 32'(ctr_mp), 32'(e[EW-1]));
        last_pass = e[EW-2 -: 2*NBP];
        seen_any = 1'b1;
      end
    end else if (rst_n && seen_any) begin
      check("R1", "held pass", 32'(pass_o), 32'(last_pass));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", "out_valid in reset", 32'(out_valid), 32'd0);
    check("R2", "pass in reset", 32'(pass_o), 32'd0);
    check("R2", "sums in reset", 32'(h_sum | v_sum | d_sum), 32'd0);
    check("R2", "ctr_mp in reset", 32'(ctr_mp), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: lone centre, leading one at bit 5
    send("R3", 8'h20, '0, 8'h00, 2'd1);
    // R4: zero centre, zero neighbours -> cleanup everywhere
    send("R4", 8'h00, '0, 8'h00, 2'd2);
    idle(2);
    // R5: right neighbour above the centre's leading one
    send("R5", 8'h01, at(4, 8'h10), 8'h00, 2'd1);
    // R6: left neighbour at equal plane, flag 1 then 0
    send("R6", 8'h04, at(3, 8'h04), 8'h08, 2'd1);
    send("R6", 8'h04, at(3, 8'h04), 8'h00, 2'd1);
    // R6: right neighbour at equal plane never counts
    send("R6", 8'h04, at(4, 8'h04), 8'h10, 2'd1);
    idle(1);
    // R7: upper-right at equal plane, row 0 counts, row 1 does not
    send("R7", 8'h08, at(2, 8'h08), 8'h04, 2'd0);
    send("R7", 8'h08, at(2, 8'h08), 8'h04, 2'd1);
    // R8: lower row neighbours large, row 3 blocks, row 2 counts
    send("R8", 8'h02, at(5, 8'hFF) | at(6, 8'hFF) | at(7, 8'hFF), 8'hE0, 2'd3);
    send("R8", 8'h02, at(5, 8'hFF) | at(6, 8'hFF) | at(7, 8'hFF), 8'hE0, 2'd2);
    // R9: all neighbours full, zero centre, all flags set
    send("R9", 8'h00, {8{8'hFF}}, 8'hFF, 2'd1);
    // R10: centre and all neighbours share leading plane, only after-slots
    send("R10", 8'h40, at(4, 8'h40) | at(6, 8'h40) | at(7, 8'h7F), 8'hFF, 2'd1);
    send("R10", 8'h40, at(1, 8'h40), 8'h02, 2'd2);
    idle(3);

    for (int i = 0; i < 60; i++) begin
      logic [8*NBP-1:0] n;
      logic [NBP-1:0]   c;
      logic [31:0]      x;
      x = rnd();
      c = 8'(x >> (rnd() % 9));
      for (int s = 0; s < 8; s++) begin
        x = rnd();
        n[s*NBP +: NBP] = (x[3:0] > 4'd11) ? c : 8'(x >> (x[31:28] % 9));
      end
      x = rnd();
      send("R4", c, n, x[7:0], x[9:8]);
      if (x[12]) idle(1);
    end
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule